// File: doc/BRIEF.md
# Repeated-Bit Serial Detector

This block watches a one-bit serial stream and raises a flag whenever the newest bit matches the one before it. A run of two or more zeros is flagged, and so is a run of two or more ones. A stream whose bits alternate keeps the flag low. The block keeps only one bit of history, so it has no notion of longer patterns or of framing.

The two clock edges do different jobs. The falling edge samples the serial input and advances a three-state machine. The states are: nothing seen yet, last bit was zero, and last bit was one. The same falling edge also captures the Mealy result, which depends on the state and the input. The following rising edge copies that result to the output pin. The output is therefore stable for the whole high phase, and it changes only on a rising edge. An active-low asynchronous reset puts the machine back in its idle state and clears the output at once. After reset, the first bit has nothing to be compared with and never raises the flag.

Top module: `rep_bit_detector`

## Requirements
- R1: While `rst_n` is low, `dup_out` is 0 whatever `ser_in` does. After reset is released, the first sampled bit never sets `dup_out` to 1.
- R2: A sampled 0 that follows a sampled 0 gives `dup_out` = 1 at the next rising edge.
- R3: A sampled 1 that follows a sampled 1 gives `dup_out` = 1 at the next rising edge.
- R4: A sampled bit that differs from the bit before it gives `dup_out` = 0 at the next rising edge.
- R5: Across a run of N equal bits, `dup_out` is 0 for the first bit of the run and 1 for each of the remaining N-1 bits.
- R6: `dup_out` changes only on a rising edge of `clk`. Its value just after a falling edge equals its value just before that falling edge.
- R7: `ser_in` is sampled only on the falling edge of `clk`. A change on `ser_in` between a falling edge and the next rising edge has no effect on `dup_out` or on the stored bit history.
- R8: Driving `rst_n` low clears `dup_out` at once, with no clock edge. After release, the first bit does not set the flag, even when it equals the last bit seen before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The falling edge samples `ser_in`; the rising edge updates `dup_out`. |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data bit |
| dup_out | output | 1 | High when the latest sampled bit equals the bit sampled before it |

## Verification
The bench targets four kinds of fault:
- **First bit after reset.** A design that compares the first bit against a stale or default history would flag it by mistake.
- **Run lengths and alternation.** Runs of both polarities, and alternating input, separate a design that compares correctly from one that flags only one polarity or inverts the comparison.
- **Split timing.** The bench reads the output just after each falling edge and changes the input during the low phase. A design that drives the output from the falling edge, or that samples the input on the rising edge, shows up as an early output change or as a result built from the wrong bit.
- **Reset in mid-stream.** A reset asserted while the flag is high must clear it without a clock edge. A design that keeps its bit history through reset would flag the next equal bit.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   localparam int unsigned RBD_STATE_W = 2;

   typedef enum logic [RBD_STATE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_LAST0 = 2'b01,
      ST_LAST1 = 2'b10
   } rbd_state_e;

   function automatic rbd_state_e rbd_next(input rbd_state_e cur, input logic bit_in);
      rbd_state_e nxt;
      case (cur)
         ST_IDLE, ST_LAST0, ST_LAST1: nxt = bit_in ? ST_LAST1 : ST_LAST0;
         default:                     nxt = ST_IDLE;
      endcase
      return nxt;
   endfunction

   function automatic logic rbd_hit(input rbd_state_e cur, input logic bit_in);
      logic h;
      case (cur)
         ST_LAST0: h = ~bit_in;
         ST_LAST1: h = bit_in;
         default:  h = 1'b0;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/rbd_fsm.sv
module rbd_fsm
   import rbd_pkg::*;
#(
   parameter int unsigned STATE_W = RBD_STATE_W
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_i,
   output logic hit_o
);

   generate
      if (STATE_W != RBD_STATE_W) begin : g_bad_width
         $error("rbd_fsm: STATE_W must equal the package state width");
      end
   endgenerate

   rbd_state_e state_q;
   rbd_state_e state_d;
   logic       hit_d;

   always_comb begin
      state_d = rbd_next(state_q, bit_i);
      hit_d   = rbd_hit(state_q, bit_i);
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hit_o   <= 1'b0;
      end else begin
         state_q <= state_d;
         hit_o   <= hit_d;
      end
   end

endmodule

// File: rtl/rbd_outreg.sv
module rbd_outreg #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rbd_outreg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/rep_bit_detector.sv
module rep_bit_detector
   import rbd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ser_in,
   output logic dup_out
);

   logic fall_hit;

   rbd_fsm #(
      .STATE_W(RBD_STATE_W)
   ) fsm_i (
      .clk  (clk),
      .rst_n(rst_n),
      .bit_i(ser_in),
      .hit_o(fall_hit)
   );

   rbd_outreg #(
      .WIDTH(1)
   ) oreg_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (fall_hit),
      .q_o  (dup_out)
   );

endmodule

// File: rtl/rbd_chk.sv
module rbd_chk (
   input logic clk,
   input logic rst_n,
   input logic ser_in,
   input logic dup_out
);

   logic       cap_prev;
   logic       cap_cur;
   logic [1:0] cap_cnt;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_prev <= 1'b0;
         cap_cur  <= 1'b0;
         cap_cnt  <= 2'd0;
      end else begin
         cap_prev <= cap_cur;
         cap_cur  <= ser_in;
         if (cap_cnt != 2'd2) cap_cnt <= cap_cnt + 2'd1;
      end
   end

   // R1: the output stays clear while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_clear_in_reset: assert (dup_out == 1'b0)
            else $error("a_r1_clear_in_reset");
      end
   end

   // R1: the first bit after reset never flags
   a_r1_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cnt == 2'd1) |=> !dup_out);

   // R2: a zero following a zero flags
   a_r2_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cnt == 2'd2 && !cap_cur && !cap_prev) |=> dup_out);

   // R3: a one following a one flags
   a_r3_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cnt == 2'd2 && cap_cur && cap_prev) |=> dup_out);

   // R4: differing neighbours do not flag
   a_r4_differ_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cnt == 2'd2 && (cap_cur != cap_prev)) |=> !dup_out);

endmodule

bind rep_bit_detector rbd_chk chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .ser_in (ser_in),
   .dup_out(dup_out)
);

// File: tb/rep_bit_detector_tb_top.sv
`timescale 1ns/1ps
module rep_bit_detector_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic ser_in = 1'b0;
   logic dup_out;

   int   n_checks = 0;
   int   n_fails  = 0;
   logic last_exp = 1'b0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   rep_bit_detector dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ser_in (ser_in),
      .dup_out(dup_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Called at rising edge + 1 ns; returns at the next rising edge + 1 ns.
   task automatic send_bit(input logic b, input logic exp, input string req,
                           input bit glitch);
      ser_in = b;
      @(negedge clk);
      #0.5;
      chk("R6 stable across falling edge", dup_out, last_exp);
      if (glitch) ser_in = ~b;
      @(posedge clk);
      #1;
      chk(req, dup_out, exp);
      last_exp = exp;
   endtask

   task automatic t_reset;
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 clear in reset", dup_out, 1'b0);
      for (int i = 0; i < 4; i++) begin
         ser_in = i[0];
         @(posedge clk);
         #1;
         chk("R1 clear in reset", dup_out, 1'b0);
      end
      rst_n    = 1'b1;
      last_exp = 1'b0;
      send_bit(1'b1, 1'b0, "R1 first bit quiet", 1'b0);
   endtask

   task automatic t_zeros;
      send_bit(1'b0, 1'b0, "R4 differ", 1'b0);
      send_bit(1'b0, 1'b1, "R2 zero pair", 1'b0);
      send_bit(1'b0, 1'b1, "R5 zero run", 1'b0);
      send_bit(1'b0, 1'b1, "R5 zero run", 1'b0);
   endtask

   task automatic t_ones;
      send_bit(1'b1, 1'b0, "R5 run start", 1'b0);
      send_bit(1'b1, 1'b1, "R3 one pair", 1'b0);
      send_bit(1'b1, 1'b1, "R5 one run", 1'b0);
   endtask

   task automatic t_alternate;
      send_bit(1'b0, 1'b0, "R4 alternate", 1'b0);
      send_bit(1'b1, 1'b0, "R4 alternate", 1'b0);
      send_bit(1'b0, 1'b0, "R4 alternate", 1'b0);
      send_bit(1'b1, 1'b0, "R4 alternate", 1'b0);
   endtask

   task automatic t_glitch;
      // last sampled bit is 1; sample 0, then flip to 1 in the low phase
      send_bit(1'b0, 1'b0, "R7 low-phase change ignored", 1'b1);
      send_bit(1'b0, 1'b1, "R7 history holds sampled bit", 1'b0);
   endtask

   task automatic t_async_reset;
      send_bit(1'b1, 1'b0, "R4 differ", 1'b0);
      send_bit(1'b1, 1'b1, "R3 one pair", 1'b0);
      rst_n = 1'b0;
      #0.5;
      chk("R8 async clear", dup_out, 1'b0);
      @(posedge clk);
      #1;
      rst_n    = 1'b1;
      last_exp = 1'b0;
      send_bit(1'b1, 1'b0, "R8 history dropped", 1'b0);
      send_bit(1'b1, 1'b1, "R8 resumes", 1'b0);
   endtask

   initial begin
      t_reset();
      t_zeros();
      t_ones();
      t_alternate();
      t_glitch();
      t_async_reset();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

endmodule